// File: doc/BRIEF.md
# JTAG Test Instruction Data-Path and Pin-Override Controller

This block sits beside an IEEE 1149.1 TAP state machine and supplies three test instructions: a user-code read, an output clamp and a global output float. It takes the decoded current instruction and the Capture-DR, Shift-DR, Shift-IR and Update-IR state flags from the TAP. From these it picks the data register that forms the serial path between TDI and TDO: a 32-bit identification register, a one-bit bypass register, or the external boundary-scan chain.

For the user-code read, the identification register loads a 32-bit code at capture time. The code comes from a shadow copy of the running configuration, and the load happens only once configuration has finished. Before that, the register loads all ones. The clamp and float instructions route the bypass register while a small state machine holds the pins. Its states are PM_NORMAL (no override), PM_CLAMP (pins driven from the boundary-scan cells) and PM_HIGHZ (all user pins floated).

The machine moves only on an Update-IR strobe. An Update-IR carrying the clamp code moves it to PM_CLAMP from any state. An Update-IR carrying the float code moves it to PM_HIGHZ from any state. An Update-IR carrying any other code returns it to PM_NORMAL. The Test-Logic-Reset flag sends it to PM_NORMAL from any state. The pad keeper (pull-up and bus-hold) enables pass through unaltered in every state. TDO is retimed on the falling edge of TCK.

Top module: `jtag_instr_path`

## Requirements
- R1: `dr_sel` (0 = bypass, 1 = ID register, 2 = boundary chain) is 1 for instruction 10'h007 and 2 for 10'h005. It is 0 for 10'h00A, for 10'h00B, for 10'h3FF and for every other code.
- R2: With `cfg_done` = 1 and instruction 10'h007, a Capture-DR cycle loads `user_code` into the ID register. Each following Shift-DR cycle then presents one bit on `tdo`, least significant bit first. Bit k is visible after the k-th falling edge that follows the capture cycle, counting from zero. After 32 bits, the `tdi` values shifted in reappear on `tdo` in the order they entered.
- R3: With `cfg_done` = 0, capture under 10'h007 loads 32'hFFFF_FFFF.
- R4: The code shifted out is the `user_code` value present at the capture edge. Later changes of `user_code` during shifting do not alter `tdo`.
- R5: The bypass register captures 0. While it is selected, `tdo` repeats `tdi` one Shift-DR cycle later. This holds under 10'h00A, 10'h00B and unrecognised codes.
- R6: An Update-IR cycle with instruction 10'h00A sets `clamp_en` = 1 and `hiz_en` = 0 from the following rising edge.
- R7: An Update-IR cycle with instruction 10'h00B sets `hiz_en` = 1 and `clamp_en` = 0. The state remains until an Update-IR cycle with a different code.
- R8: `clamp_en` and `hiz_en` never change on a rising edge without Update-IR or Test-Logic-Reset. A change of `instr` alone has no effect on them.
- R9: `in_tlr` = 1 clears `clamp_en` and `hiz_en` at the next rising edge. It takes precedence over Update-IR.
- R10: `tdo` and `tdo_oe` change only on falling TCK edges. `tdo_oe` is 1 only after a falling edge at which Shift-DR or Shift-IR was high. During Shift-IR, `tdo` carries `ir_so`. With the boundary chain selected, `tdo` carries `bsr_so`.
- R11: `keeper_out` equals `keeper_in` in every override state.
- R12: After reset, `clamp_en`, `hiz_en` and `tdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| in_tlr | input | 1 | TAP is in Test-Logic-Reset |
| instr | input | 10 | Decoded current instruction |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| tdi | input | 1 | Serial test data in |
| ir_so | input | 1 | Serial out of the instruction register |
| bsr_so | input | 1 | Serial out of the boundary-scan chain |
| cfg_done | input | 1 | Configuration has completed |
| user_code | input | 32 | User code from the shadow copy |
| keeper_in | input | 8 | Pad pull-up / bus-hold enables |
| dr_sel | output | 2 | Selected data register |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | TDO driver enable |
| clamp_en | output | 1 | Drive pins from boundary-scan cells |
| hiz_en | output | 1 | Float all user pins |
| keeper_out | output | 8 | Pad keeper enables to pads |

## Verification
The assertions assume that the TAP raises at most one of its state flags per cycle. They also assume that `instr` already holds the new code during the Update-IR cycle, and that `in_tlr` is asserted only outside shifting. The random stimulus draws one flag per cycle, with Test-Logic-Reset drawn on its own. It picks codes from the defined set plus arbitrary values, and it changes `instr` only when no shift is in progress. The directed sequences follow the order Capture-DR, then Shift-DR, then idle, as a real TAP would.

// File: rtl/jip_pkg.sv
package jip_pkg;
    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BSR = 2'd2
    } dr_sel_t;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_CLAMP  = 2'd1,
        PM_HIGHZ  = 2'd2
    } pin_mode_t;
endpackage

// File: rtl/jip_decode.sv
module jip_decode
    import jip_pkg::*;
#(
    parameter int              IR_W      = 10,
    parameter logic [IR_W-1:0] UCODE_OP  = 10'h007,
    parameter logic [IR_W-1:0] BOUND_OP  = 10'h005
) (
    input  logic [IR_W-1:0] instr,
    output dr_sel_t         sel
);
    always_comb begin
        if (instr == UCODE_OP)      sel = SEL_ID;
        else if (instr == BOUND_OP) sel = SEL_BSR;
        else                        sel = SEL_BYP;
    end
endmodule

// File: rtl/jip_mode_fsm.sv
module jip_mode_fsm
    import jip_pkg::*;
#(
    parameter int              IR_W     = 10,
    parameter logic [IR_W-1:0] CLAMP_OP = 10'h00A,
    parameter logic [IR_W-1:0] HIGHZ_OP = 10'h00B
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            in_tlr,
    input  logic            update_ir,
    input  logic [IR_W-1:0] instr,
    output logic            clamp_en,
    output logic            hiz_en
);
    pin_mode_t state_q, state_d, req_mode;

    always_comb begin
        if (instr == CLAMP_OP)      req_mode = PM_CLAMP;
        else if (instr == HIGHZ_OP) req_mode = PM_HIGHZ;
        else                        req_mode = PM_NORMAL;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_NORMAL: if (update_ir) state_d = req_mode;
            PM_CLAMP:  if (update_ir) state_d = req_mode;
            PM_HIGHZ:  if (update_ir) state_d = req_mode;
            default:   state_d = PM_NORMAL;
        endcase
        if (in_tlr) state_d = PM_NORMAL;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= PM_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        clamp_en = 1'b0;
        hiz_en   = 1'b0;
        unique case (state_q)
            PM_NORMAL: ;
            PM_CLAMP:  clamp_en = 1'b1;
            PM_HIGHZ:  hiz_en   = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/jip_shift.sv
module jip_shift
    import jip_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic            tck,
    input  logic            rst_n,
    input  dr_sel_t         sel,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            shift_ir,
    input  logic            tdi,
    input  logic            ir_so,
    input  logic            bsr_so,
    input  logic            cfg_done,
    input  logic [ID_W-1:0] user_code,
    output logic            tdo,
    output logic            tdo_oe
);
    logic [ID_W-1:0] id_sr;
    logic            byp_q;
    logic            so_mux;

    always_ff @(posedge tck) begin
        if (sel == SEL_ID) begin
            if (capture_dr)    id_sr <= cfg_done ? user_code : {ID_W{1'b1}};
            else if (shift_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
        if (capture_dr)    byp_q <= 1'b0;
        else if (shift_dr) byp_q <= tdi;
    end

    always_comb begin
        if (shift_ir) so_mux = ir_so;
        else begin
            unique case (sel)
                SEL_ID:  so_mux = id_sr[0];
                SEL_BSR: so_mux = bsr_so;
                default: so_mux = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= so_mux;
            tdo_oe <= shift_dr | shift_ir;
        end
    end
endmodule

// File: rtl/jtag_instr_path.sv
module jtag_instr_path
    import jip_pkg::*;
#(
    parameter int              IR_W     = 10,
    parameter int              ID_W     = 32,
    parameter int              NPINS    = 8,
    parameter logic [IR_W-1:0] UCODE_OP = 10'h007,
    parameter logic [IR_W-1:0] BOUND_OP = 10'h005,
    parameter logic [IR_W-1:0] CLAMP_OP = 10'h00A,
    parameter logic [IR_W-1:0] HIGHZ_OP = 10'h00B
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             in_tlr,
    input  logic [IR_W-1:0]  instr,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             shift_ir,
    input  logic             update_ir,
    input  logic             tdi,
    input  logic             ir_so,
    input  logic             bsr_so,
    input  logic             cfg_done,
    input  logic [ID_W-1:0]  user_code,
    input  logic [NPINS-1:0] keeper_in,
    output logic [1:0]       dr_sel,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             clamp_en,
    output logic             hiz_en,
    output logic [NPINS-1:0] keeper_out
);
    dr_sel_t sel;

    jip_decode #(.IR_W(IR_W), .UCODE_OP(UCODE_OP), .BOUND_OP(BOUND_OP)) u_dec (
        .instr (instr),
        .sel   (sel)
    );

    jip_mode_fsm #(.IR_W(IR_W), .CLAMP_OP(CLAMP_OP), .HIGHZ_OP(HIGHZ_OP)) u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .in_tlr    (in_tlr),
        .update_ir (update_ir),
        .instr     (instr),
        .clamp_en  (clamp_en),
        .hiz_en    (hiz_en)
    );

    jip_shift #(.ID_W(ID_W)) u_sh (
        .tck        (tck),
        .rst_n      (rst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .shift_ir   (shift_ir),
        .tdi        (tdi),
        .ir_so      (ir_so),
        .bsr_so     (bsr_so),
        .cfg_done   (cfg_done),
        .user_code  (user_code),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe)
    );

    assign dr_sel     = sel;
    assign keeper_out = keeper_in;
endmodule

// File: rtl/jip_chk.sv
module jip_chk #(
    parameter int              IR_W     = 10,
    parameter logic [IR_W-1:0] HIGHZ_OP = 10'h00B
) (
    input logic            tck,
    input logic            rst_n,
    input logic            in_tlr,
    input logic            update_ir,
    input logic [IR_W-1:0] instr,
    input logic            clamp_en,
    input logic            hiz_en
);
    // R6
    exclusive_override_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !(clamp_en && hiz_en));

    // R8
    mode_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!update_ir && !in_tlr) |=> ($stable(clamp_en) && $stable(hiz_en)));

    // R9
    tlr_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
        in_tlr |=> (!clamp_en && !hiz_en));

    // R7
    highz_enter_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_ir && !in_tlr && instr == HIGHZ_OP) |=> (hiz_en && !clamp_en));
endmodule

bind jtag_instr_path jip_chk #(.IR_W(IR_W), .HIGHZ_OP(HIGHZ_OP)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .in_tlr    (in_tlr),
    .update_ir (update_ir),
    .instr     (instr),
    .clamp_en  (clamp_en),
    .hiz_en    (hiz_en)
);

// File: tb/jtag_instr_path_tb.sv
`timescale 1ns/1ps
module jtag_instr_path_tb;
    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_tlr = 1'b0;
    logic [9:0]  instr = 10'h3FF;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
    logic        tdi = 1'b0, ir_so = 1'b0, bsr_so = 1'b0, cfg_done = 1'b0;
    logic [31:0] user_code = 32'h0;
    logic [7:0]  keeper_in = 8'h0;
    logic [1:0]  dr_sel;
    logic        tdo, tdo_oe, clamp_en, hiz_en;
    logic [7:0]  keeper_out;

    int checks = 0;
    int errors = 0;
    logic       m_clamp = 1'b0, m_hiz = 1'b0;

    always #2.5 tck = ~tck;

    jtag_instr_path u_dut (.*);

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [9:0] c);
        if (c == 10'h007) return 2'd1;
        if (c == 10'h005) return 2'd2;
        return 2'd0;
    endfunction

    task automatic tick();
        @(posedge tck); #1;
    endtask

    task automatic model_edge();
        if (in_tlr) begin m_clamp = 0; m_hiz = 0; end
        else if (update_ir) begin
            m_clamp = (instr == 10'h00A);
            m_hiz   = (instr == 10'h00B);
        end
    endtask

    task automatic load_ir(input logic [9:0] c);
        instr = c; update_ir = 1; model_edge(); tick(); update_ir = 0;
    endtask

    task automatic check_mode(input string req);
        check(clamp_en === m_clamp, req, 64'(clamp_en), 64'(m_clamp));
        check(hiz_en === m_hiz, req, 64'(hiz_en), 64'(m_hiz));
    endtask

    // Capture then shift n bits; expected per bit from code (ID) or delayed tdi (bypass)
    task automatic dr_scan(input bit is_id, input logic [31:0] code, input int n,
                           input bit poke_code, input string req);
        logic [63:0] tin;
        logic        e;
        tin = {$urandom, $urandom};
        capture_dr = 1; tick(); capture_dr = 0; shift_dr = 1;
        for (int k = 0; k < n; k++) begin
            tdi = tin[k];
            if (poke_code && k == 3) user_code = ~user_code;
            @(negedge tck); #1;
            if (is_id) e = (k < 32) ? code[k] : tin[k-32];
            else       e = (k == 0) ? 1'b0 : tin[k-1];
            check(tdo === e && tdo_oe === 1'b1, req, {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, e});
            tick();
        end
        shift_dr = 0;
        @(negedge tck); #1;
        check(tdo_oe === 1'b0, "R10 oe low after shift", 64'(tdo_oe), 64'd0);
        tick();
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] c;
        logic [9:0]  codes [6];
        void'($urandom(32'h5EED_0042));
        codes = '{10'h007, 10'h00A, 10'h00B, 10'h005, 10'h3FF, 10'h000};
        repeat (3) tick();
        rst_n = 1; tick();
        // R12 reset state
        check(clamp_en === 0 && hiz_en === 0 && tdo_oe === 0, "R12 reset",
              {61'd0, clamp_en, hiz_en, tdo_oe}, 64'd0);

        // R1 select decode
        foreach (codes[i]) begin
            instr = codes[i]; #1;
            check(dr_sel === exp_sel(codes[i]), "R1 dr_sel", 64'(dr_sel), 64'(exp_sel(codes[i])));
        end
        instr = 10'h123; #1;
        check(dr_sel === 2'd0, "R1 unknown code", 64'(dr_sel), 64'd0);

        // R3 unconfigured capture
        load_ir(10'h007);
        user_code = 32'h1234_5678; cfg_done = 0;
        dr_scan(1, 32'hFFFF_FFFF, 32, 0, "R3 unconfigured");
        // R2 configured capture with tdi follow-through
        cfg_done = 1; c = $urandom; user_code = c;
        dr_scan(1, c, 40, 0, "R2 user code shift");
        // R4 shadow value held
        c = $urandom; user_code = c;
        dr_scan(1, c, 32, 1, "R4 capture snapshot");

        // R6 clamp, R5 bypass under clamp
        load_ir(10'h00A); check_mode("R6 clamp");
        dr_scan(0, 0, 12, 0, "R5 bypass clamp");
        // R8 instr change ignored without update
        instr = 10'h00B; tick(); tick(); check_mode("R8 no update");
        // R7 highz, persists
        load_ir(10'h00B); check_mode("R7 highz");
        dr_scan(0, 0, 12, 0, "R5 bypass highz");
        instr = 10'h007; repeat (3) tick(); check_mode("R7 persists");
        load_ir(10'h2C4); check_mode("R7 left on other code");
        dr_scan(0, 0, 8, 0, "R5 bypass unknown");
        // R9 reset priority
        load_ir(10'h00A);
        instr = 10'h00B; update_ir = 1; in_tlr = 1; model_edge(); tick();
        update_ir = 0; in_tlr = 0; check_mode("R9 tlr priority");

        // R10 shift-IR and boundary chain
        shift_ir = 1;
        for (int k = 0; k < 6; k++) begin
            ir_so = k[0] ^ k[1];
            @(negedge tck); #1;
            check(tdo === ir_so && tdo_oe === 1, "R10 shift-ir", 64'(tdo), 64'(ir_so));
            tick();
        end
        shift_ir = 0;
        load_ir(10'h005); shift_dr = 1;
        for (int k = 0; k < 6; k++) begin
            bsr_so = ~k[0];
            @(negedge tck); #1;
            check(tdo === bsr_so, "R10 boundary", 64'(tdo), 64'(bsr_so));
            tick();
        end
        shift_dr = 0; tick();

        // Random mode and decode traffic
        for (int it = 0; it < 300; it++) begin
            int r;
            r = $urandom_range(0, 6);
            instr = (r == 6) ? 10'($urandom) : codes[r];
            update_ir = ($urandom_range(0, 2) == 0);
            in_tlr = ($urandom_range(0, 7) == 0);
            if (in_tlr) update_ir = 0;
            keeper_in = 8'($urandom);
            model_edge();
            tick();
            check_mode("R8 random mode");
            check(dr_sel === exp_sel(instr), "R1 random", 64'(dr_sel), 64'(exp_sel(instr)));
            check(keeper_out === keeper_in, "R11 keeper pass", 64'(keeper_out), 64'(keeper_in));
            update_ir = 0; in_tlr = 0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule